// File: doc/BRIEF.md
# Bit-serial compute-in-memory macro

This block holds a square matrix of small unsigned weights in local storage and multiplies it by a vector of unsigned input values. It has 64 weight columns by default, each holding 64 four-bit weights. A single write loads one row position across every column at once: the 256-bit data word carries one four-bit weight for each column.

A start pulse captures the 64 four-bit inputs. The macro then consumes one bit-plane of those inputs per clock, beginning with the most significant bit. On every compute cycle, each column gates its stored weights with the current input bit of the matching element. A combinational binary adder tree with six levels sums the gated weights, and the result is folded into a per-column register that doubles its old value and adds the new sum. After four compute cycles, each column holds its full inner product as a 14-bit value. A one-cycle done pulse marks the point where the results are valid, and the results stay on the output until the next start.

Top module: `cim_macro`

## Requirements
- R1: After reset, `busy` and `done` are low and every 14-bit field of `result` is zero.
- R2: With `wr_en` high, `wr_addr` below 64 and `busy` low, bits `wr_data[4c+3:4c]` are stored as the weight of column c at row `wr_addr`.
- R3: A write with `wr_addr` of 64 or more changes no stored weight.
- R4: A write presented while `busy` is high changes no stored weight.
- R5: A `start` seen while idle raises `busy` on the next cycle. `busy` then stays high for exactly four cycles. `done` is high for exactly one cycle, and that cycle is the first one in which `busy` is low again.
- R6: When `done` is high, `result[14c+13:14c]` equals the sum over j of w[c][j]·x[j]. Here x[j] is `x_in[4j+3:4j]` as captured at the accepted start, and w[c][j] is column c's weight at row j.
- R7: Input bits are consumed most significant first. After k compute cycles (k = 1..4), column c shows the sum over j of w[c][j]·(x[j] >> (4−k)).
- R8: A `start` that arrives while `busy` is high is ignored. It neither restarts the computation nor recaptures `x_in`.
- R9: While idle, `result` keeps its last value until the next accepted start, even across weight writes.
- R10: All-maximum operands (every weight 15 and every input 15) produce 14400 in each column without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Weight row write request |
| wr_addr | input | 8 | Row position to write; legal range 0..63 |
| wr_data | input | 256 | One 4-bit weight per column; column c at bits 4c+3:4c |
| start | input | 1 | Begin a matrix-vector product |
| x_in | input | 256 | Input vector; element j at bits 4j+3:4j |
| busy | output | 1 | High during the four compute cycles |
| done | output | 1 | One-cycle pulse when results are valid |
| result | output | 896 | Column results; column c at bits 14c+13:14c |

## Verification
The embedded properties check, on every cycle, the sequencing of the control path: the count-down length of the busy window, the single-cycle shape of done and its exclusion with busy, the MSB-first order of bit selection, and the holding of `result` while idle. Only the bench's scenarios can show the arithmetic. It compares every column against an integer model after each cycle (the partial sums) and at done. It also checks that illegal-address writes and mid-computation writes leave no trace, that a second start during a run leaves the captured inputs unchanged, and that all-maximum operands do not overflow.

// File: rtl/cim_pkg.sv
package cim_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } cim_state_e;

   // Width that holds the sum of n products of a w-bit weight and one bit
   function automatic int unsigned plane_sum_width(int unsigned n, int unsigned w);
      return w + $clog2(n);
   endfunction
endpackage

// File: rtl/cim_adder_tree.sv
module cim_adder_tree #(
   parameter int unsigned N     = 64,
   parameter int unsigned WBITS = 4,
   parameter int unsigned SUMW  = cim_pkg::plane_sum_width(N, WBITS)
) (
   input  logic [N*WBITS-1:0] w_flat,
   input  logic [N-1:0]       gate,
   output logic [SUMW-1:0]    sum
);
   localparam int unsigned LVLS = $clog2(N);

   if ((1 << LVLS) != N) begin : g_bad_n
      $error("cim_adder_tree: N must be a power of two");
   end
   if (SUMW < WBITS + LVLS) begin : g_bad_w
      $error("cim_adder_tree: SUMW too narrow for the tree");
   end

   // heap layout: node 1 is the root, leaves at N..2N-1
   logic [SUMW-1:0] node [1:2*N-1];

   for (genvar j = 0; j < N; j++) begin : g_leaf
      assign node[N+j] = gate[j] ? SUMW'(w_flat[j*WBITS +: WBITS]) : '0;
   end

   for (genvar i = 1; i < N; i++) begin : g_node
      assign node[i] = node[2*i] + node[2*i+1];
   end

   assign sum = node[1];
endmodule

// File: rtl/cim_column.sv
module cim_column #(
   parameter int unsigned ROWS  = 64,
   parameter int unsigned WBITS = 4,
   parameter int unsigned AW    = $clog2(ROWS),
   parameter int unsigned SUMW  = cim_pkg::plane_sum_width(ROWS, WBITS)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    row,
   input  logic [WBITS-1:0] wdata,
   input  logic [ROWS-1:0]  xbit,
   output logic [SUMW-1:0]  sum
);
   logic [WBITS-1:0]      store [ROWS];
   logic [ROWS*WBITS-1:0] w_flat;

   always_ff @(posedge clk) begin
      if (we) store[row] <= wdata;
   end

   for (genvar j = 0; j < ROWS; j++) begin : g_pack
      assign w_flat[j*WBITS +: WBITS] = store[j];
   end

   cim_adder_tree #(
      .N    (ROWS),
      .WBITS(WBITS),
      .SUMW (SUMW)
   ) i_tree (
      .w_flat(w_flat),
      .gate  (xbit),
      .sum   (sum)
   );
endmodule

// File: rtl/cim_shift_acc.sv
module cim_shift_acc #(
   parameter int unsigned SUMW = 10,
   parameter int unsigned OUTW = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            en,
   input  logic [SUMW-1:0] plane,
   output logic [OUTW-1:0] acc
);
   if (OUTW <= SUMW) begin : g_bad_w
      $error("cim_shift_acc: OUTW must exceed SUMW");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= {acc[OUTW-2:0], 1'b0} + OUTW'(plane);
   end
endmodule

// File: rtl/cim_seq.sv
module cim_seq #(
   parameter int unsigned XBITS = 4,
   parameter int unsigned BW    = (XBITS > 1) ? $clog2(XBITS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic          launch,
   output logic [BW-1:0] bit_sel
);
   import cim_pkg::*;

   cim_state_e    state_q;
   logic [BW-1:0] bit_q;
   logic          done_q;

   assign launch  = start && (state_q == ST_IDLE);
   assign busy    = (state_q == ST_RUN);
   assign done    = done_q;
   assign bit_sel = bit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_RUN;
               bit_q   <= BW'(XBITS - 1);
            end
            ST_RUN: if (bit_q == '0) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end else begin
               bit_q <= bit_q - 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_LAST_PLANE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      busy && bit_q == '0 |=> !busy && done); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy && bit_sel == BW'(XBITS - 1)); // R7
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && bit_q != '0 |=> busy && bit_sel == $past(bit_sel) - 1'b1); // R8
endmodule

// File: rtl/cim_macro.sv
module cim_macro #(
   parameter int unsigned ROWS  = 64,
   parameter int unsigned COLS  = 64,
   parameter int unsigned WBITS = 4,
   parameter int unsigned XBITS = 4,
   parameter int unsigned ADDRW = 8,
   parameter int unsigned OUTW  = WBITS + $clog2(ROWS) + XBITS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDRW-1:0]        wr_addr,
   input  logic [COLS*WBITS-1:0]   wr_data,
   input  logic                    start,
   input  logic [ROWS*XBITS-1:0]   x_in,
   output logic                    busy,
   output logic                    done,
   output logic [COLS*OUTW-1:0]    result
);
   localparam int unsigned AW   = $clog2(ROWS);
   localparam int unsigned SUMW = cim_pkg::plane_sum_width(ROWS, WBITS);
   localparam int unsigned BW   = (XBITS > 1) ? $clog2(XBITS) : 1;

   if (ADDRW < AW) begin : g_bad_addr
      $error("cim_macro: ADDRW cannot index all rows");
   end
   if (OUTW < SUMW + XBITS) begin : g_bad_out
      $error("cim_macro: OUTW cannot hold a full inner product");
   end

   logic          launch;
   logic [BW-1:0] bit_sel;
   logic          addr_ok;
   logic          wr_ok;
   logic [XBITS-1:0] x_q  [ROWS];
   logic [ROWS-1:0]  xbit;

   cim_seq #(
      .XBITS(XBITS),
      .BW   (BW)
   ) i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .busy   (busy),
      .done   (done),
      .launch (launch),
      .bit_sel(bit_sel)
   );

   // address range filter: only needed when the bus can exceed the row count
   if (ADDRW > AW) begin : g_addr_range
      assign addr_ok = (wr_addr < ADDRW'(ROWS));
   end else begin : g_addr_full
      assign addr_ok = 1'b1;
   end

   assign wr_ok = wr_en && addr_ok && !busy;

   always_ff @(posedge clk) begin
      if (launch) begin
         for (int j = 0; j < ROWS; j++) x_q[j] <= x_in[j*XBITS +: XBITS];
      end
   end

   for (genvar j = 0; j < ROWS; j++) begin : g_plane
      assign xbit[j] = x_q[j][bit_sel];
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [SUMW-1:0] plane_sum;

      cim_column #(
         .ROWS (ROWS),
         .WBITS(WBITS),
         .AW   (AW),
         .SUMW (SUMW)
      ) i_column (
         .clk  (clk),
         .we   (wr_ok),
         .row  (wr_addr[AW-1:0]),
         .wdata(wr_data[c*WBITS +: WBITS]),
         .xbit (xbit),
         .sum  (plane_sum)
      );

      cim_shift_acc #(
         .SUMW(SUMW),
         .OUTW(OUTW)
      ) i_acc (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (launch),
         .en   (busy),
         .plane(plane_sum),
         .acc  (result[c*OUTW +: OUTW])
      );
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(result)); // R9
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R5
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> result == '0); // R5
endmodule

// File: tb/test_cim_macro.sv
module test_cim_macro;
   localparam int NR = 64;
   localparam int NC = 64;
   localparam int OW = 14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [7:0]        wr_addr = '0;
   logic [NC*4-1:0]   wr_data = '0;
   logic              start = 1'b0;
   logic [NR*4-1:0]   x_in = '0;
   logic              busy;
   logic              done;
   logic [NC*OW-1:0]  result;

   always #5 clk = ~clk;

   cim_macro i_cim_macro (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .start  (start),
      .x_in   (x_in),
      .busy   (busy),
      .done   (done),
      .result (result)
   );

   int wm [NC][NR];
   int n_chk = 0;
   int n_fail = 0;
   logic [NC*OW-1:0] exp_q [$];
   logic [NC*OW-1:0] last_exp = '0;

   task automatic chk(bit ok, string req, longint act, longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic int dot(int c, logic [NR*4-1:0] x, int k);
      int s = 0;
      for (int j = 0; j < NR; j++) s += wm[c][j] * (int'(x[j*4 +: 4]) >> (4 - k));
      return s;
   endfunction

   function automatic logic [NC*4-1:0] rnd_word();
      logic [NC*4-1:0] d;
      for (int c = 0; c < NC; c++) d[c*4 +: 4] = 4'($urandom_range(0, 15));
      return d;
   endfunction

   task automatic wr_row(int row, logic [NC*4-1:0] d, bit model);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'(row); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (model) for (int c = 0; c < NC; c++) wm[c][row] = int'(d[c*4 +: 4]);
   endtask

   // driver: pushes expected results, then runs one product
   task automatic run_op(logic [NR*4-1:0] x, bit disturb);
      logic [NC*OW-1:0] ev;
      logic [NC*4-1:0] flip;
      for (int c = 0; c < NC; c++) ev[c*OW +: OW] = OW'(dot(c, x, 4));
      exp_q.push_back(ev);
      last_exp = ev;
      @(negedge clk);
      start = 1'b1; x_in = x;
      @(negedge clk);
      chk(busy == 1'b1, "R5 busy after start", longint'(busy), 1);
      if (disturb) begin
         // R4 write and R8 second start while busy
         for (int c = 0; c < NC; c++) flip[c*4 +: 4] = 4'(wm[c][0]) ^ 4'hF;
         start = 1'b1; x_in = ~x;
         wr_en = 1'b1; wr_addr = 8'd0; wr_data = flip;
      end else begin
         start = 1'b0;
      end
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         start = 1'b0; wr_en = 1'b0;
         for (int c = 0; c < NC; c += 9)
            chk(result[c*OW +: OW] == OW'(dot(c, x, k)), "R7 partial sum",
                longint'(result[c*OW +: OW]), longint'(dot(c, x, k)));
         chk(busy == (k < 4), "R5 busy window", longint'(busy), longint'(k < 4));
         chk(done == (k == 4), "R5 done timing", longint'(done), longint'(k == 4));
      end
      @(negedge clk);
      chk(done == 1'b0, "R5 done single cycle", longint'(done), 0);
   endtask

   // monitor: pops and compares at every done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected done", 1, 0);
         end else begin
            logic [NC*OW-1:0] e;
            e = exp_q.pop_front();
            for (int c = 0; c < NC; c++)
               chk(result[c*OW +: OW] == e[c*OW +: OW], "R6 column result",
                   longint'(result[c*OW +: OW]), longint'(e[c*OW +: OW]));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [NR*4-1:0] x;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy after reset", longint'(busy), 0);
      chk(done == 1'b0, "R1 done after reset", longint'(done), 0);
      chk(result == '0, "R1 result after reset", longint'(result[OW-1:0]), 0);

      // R2 load a random matrix
      for (int r = 0; r < NR; r++) wr_row(r, rnd_word(), 1'b1);
      run_op(rnd_word(), 1'b0);

      // R2 single nonzero element exposes row mapping
      x = '0; x[5*4 +: 4] = 4'hB;
      run_op(x, 1'b0);
      x = '0; x[63*4 +: 4] = 4'h8; x[0 +: 4] = 4'h1;
      run_op(x, 1'b0);

      // R3 out-of-range writes that would alias rows 0, 8, 63
      wr_row(0, '0, 1'b1);
      wr_row(8, '0, 1'b1);
      wr_row(63, '0, 1'b1);
      wr_row(64, '1, 1'b0);
      wr_row(200, '1, 1'b0);
      wr_row(127, '1, 1'b0);
      run_op('1, 1'b0);   // R3 checked by R6 compare with all inputs active

      // R4 and R8: write and restart attempt during a run
      run_op(rnd_word(), 1'b1);
      run_op('1, 1'b0);   // R4 row 0 must still be zero

      // R9 results hold across idle cycles and a legal write
      repeat (5) @(negedge clk);
      wr_row(3, rnd_word(), 1'b1);
      for (int c = 0; c < NC; c += 7)
         chk(result[c*OW +: OW] == last_exp[c*OW +: OW], "R9 hold while idle",
             longint'(result[c*OW +: OW]), longint'(last_exp[c*OW +: OW]));

      // R10 all-maximum operands
      for (int r = 0; r < NR; r++) wr_row(r, '1, 1'b1);
      run_op('1, 1'b0);
      chk(result[0 +: OW] == 14'd14400, "R10 max column 0",
          longint'(result[0 +: OW]), 14400);
      chk(result[(NC-1)*OW +: OW] == 14'd14400, "R10 max last column",
          longint'(result[(NC-1)*OW +: OW]), 14400);

      // back-to-back random products with random matrices
      for (int t = 0; t < 3; t++) begin
         for (int r = 0; r < NR; r++) wr_row(r, rnd_word(), 1'b1);
         run_op(rnd_word(), 1'b0);
      end

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R6 results outstanding", longint'(exp_q.size()), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule